// File: doc/BRIEF.md
# SPI Multichannel ADC Scan Sequencer

This block is an SPI master for a serial eight-input converter with a one-frame delay: a sample comes back one 16-bit frame after the frame that names its channel. A scan starts on a one-cycle trigger and is qualified by an enable mask. The sequencer keeps chip select low and sends one command frame for each enabled input, lowest index first. It then adds one all-zero frame so that the last result can shift out. The reply received during the first frame of a transfer belongs to no channel and is dropped. Every later reply is stored in the slot of the channel named one frame earlier.

A direct read fetches a single channel outside a scan. It uses a two-frame transfer, a command frame and then a blank frame, and the result goes to a separate output. While a transfer is in progress the sequencer takes no new work. A direct request in that time is refused with a one-cycle pulse, and a trigger in that time increments a saturating overrun counter. The serial clock is derived from the system clock through a half-period divider that can be changed at run time.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, cs_n and sclk are high, busy is low, sample_valid and overrun_cnt are zero and direct_valid is low. Whenever cs_n is high, sclk is high (clock polarity and phase mode 3).
- R2: Every frame is 16 bits, MSB first. MOSI changes on the falling sclk edge and is stable at the rising edge. A command frame carries the channel number in bits [13:11], and all its other bits are zero.
- R3: The reply to the first frame of a transfer is discarded. The reply to frame N is the sample for the channel commanded in frame N-1. Only bits [11:0] are kept, and the reply's bits [15:12] are zero.
- R4: A scan commands the enabled channels in ascending order and skips disabled ones. It then sends one all-zero frame, so the frame count is popcount(mask)+1.
- R5: cs_n falls once per transfer, stays low across all of its frames and rises only after the last frame.
- R6: scan_done (after a scan) or direct_done (after a direct read) pulses for one cycle, one cycle after cs_n rises.
- R7: At scan completion, sample_valid equals the enable mask. Channel i's sample is at samples[12*i+11:12*i]. The flags are cleared when a scan is accepted.
- R8: A direct read of channel c is two frames, command c then all-zero. It sets direct_data to c's sample and direct_valid high, and leaves samples and sample_valid unchanged.
- R9: A direct_req while busy is not executed. direct_refused pulses in the next cycle, and the running transfer completes unaffected.
- R10: A scan_trig while busy increments overrun_cnt, saturating at all ones, and does not disturb the running scan.
- R11: A scan with an all-zero mask produces no cs_n or sclk activity and completes with scan_done two cycles after the trigger, with sample_valid zero.
- R12: Each sclk low phase and each sclk high phase inside a frame last clk_div+1 system clock cycles.
- R13: If scan_trig and direct_req arrive together while idle, the scan runs and the direct request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | input | DIV_W | sclk half period minus one, in clk cycles |
| scan_trig | input | 1 | One-cycle scan start pulse |
| chan_mask | input | NCH | Channel enable mask sampled with scan_trig |
| direct_req | input | 1 | One-cycle direct single-channel read request |
| direct_chan | input | CH_W | Channel for the direct read |
| sclk | output | 1 | SPI serial clock, idles high |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Reply data from the converter |
| busy | output | 1 | A transfer is in progress |
| scan_done | output | 1 | Scan completion pulse |
| samples | output | NCH*SW | Packed per-channel samples |
| sample_valid | output | NCH | Per-channel valid flags of the last scan |
| direct_done | output | 1 | Direct read completion pulse |
| direct_data | output | SW | Result of the last direct read |
| direct_valid | output | 1 | direct_data holds a completed result |
| direct_refused | output | 1 | Direct request was refused |
| overrun_cnt | output | OVR_W | Saturating count of triggers seen while busy |

## Verification
The bench uses the default parameters: eight channels, 12-bit samples, an 8-bit divider and an 8-bit overrun counter. It changes clk_div between 0 and 3 at run time, which exercises both the tightest sclk timing and a stretched one. The converter model in the bench has a one-frame reply delay. It puts a nonzero junk word in each transfer's first reply, so a sequencer that kept the first reply or paired a reply with the wrong channel shows up in the stored samples. Masks of one, several, all and no channels, including the edge channels 0 and 7, cover the ascending ordering and the trailing blank frame.

// File: rtl/adcseq_pkg.sv
// Package: shared constants, controller state type and the command word builder
// for the scan sequencer. Assumes a 16-bit frame with a 3-bit channel field.
package adcseq_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 3;
    localparam int ADDR_LSB   = 11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

    // Builds a command frame: channel in [13:11], every other bit zero.
    function automatic logic [FRAME_BITS-1:0] mk_cmd(input logic [ADDR_W-1:0] ch);
        logic [FRAME_BITS-1:0] w;
        w = '0;
        w[ADDR_LSB +: ADDR_W] = ch;
        return w;
    endfunction

endpackage

// File: rtl/adcseq_spi_engine.sv
// Module: adcseq_spi_engine
// Shifts one 16-bit mode-3 frame. MOSI is updated on the falling sclk edge and
// MISO is sampled on the rising edge. Assumes start is only pulsed when idle.
// Each sclk phase lasts half_div+1 clk cycles.
module adcseq_spi_engine
    import adcseq_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic [DIV_W-1:0]      half_div,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  frame_done,
    output logic [FRAME_BITS-1:0] rx_word
);
    localparam int BC_W = $clog2(FRAME_BITS);

    logic                  active;
    logic [DIV_W-1:0]      hcnt;
    logic [BC_W-1:0]       bcnt;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [FRAME_BITS-1:0] rx_sh;

    // Frame shifter: phase timer, edge generation, shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            sclk       <= 1'b1;
            mosi       <= 1'b0;
            hcnt       <= '0;
            bcnt       <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            frame_done <= 1'b0;
            rx_word    <= '0;
        end else begin
            frame_done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    tx_sh  <= tx_word;
                    hcnt   <= '0;
                    bcnt   <= '0;
                end
            end else if (hcnt == half_div) begin
                hcnt <= '0;
                if (sclk) begin
                    sclk  <= 1'b0;
                    mosi  <= tx_sh[FRAME_BITS-1];
                    tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                end else begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[FRAME_BITS-2:0], miso};
                    if (bcnt == BC_W'(FRAME_BITS-1)) begin
                        active     <= 1'b0;
                        frame_done <= 1'b1;
                        rx_word    <= {rx_sh[FRAME_BITS-2:0], miso};
                        bcnt       <= '0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // R2: a frame ends on a rising edge, leaving the clock at its idle level.
    a_r2_frame_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> sclk);

    // R12: while the engine is idle the clock holds its level.
    a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> $stable(sclk));

endmodule

// File: rtl/adcseq_chan_pick.sv
// Module: adcseq_chan_pick
// Finds the lowest set bit of a channel mask (ascending visit order).
// Purely combinational; idx is zero when no bit is set.
module adcseq_chan_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  mask,
    output logic            any,
    output logic [CH_W-1:0] idx
);
    logic [NCH-1:0] first;
    logic [NCH-1:0] below;

    // One stage per channel: set when this is the lowest enabled channel.
    for (genvar i = 0; i < NCH; i++) begin : g_stage
        if (i == 0) begin : g_lsb
            assign below[i] = 1'b0;
        end else begin : g_up
            assign below[i] = below[i-1] | mask[i-1];
        end
        assign first[i] = mask[i] & ~below[i];
    end

    // Encode the one-hot winner to a channel index.
    always_comb begin
        idx = '0;
        for (int k = 0; k < NCH; k++) begin
            if (first[k]) idx = idx | CH_W'(k);
        end
    end

    assign any = |mask;

endmodule

// File: rtl/adcseq_result_bank.sv
// Module: adcseq_result_bank
// Per-channel sample registers with valid flags. clear drops all flags,
// a write stores one sample and raises its flag. Assumes clear and wr_en are
// never high together.
module adcseq_result_bank #(
    parameter int NCH  = 8,
    parameter int SW   = 12,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [SW-1:0]     wr_data,
    output logic [NCH*SW-1:0] samples,
    output logic [NCH-1:0]    valid
);
    for (genvar i = 0; i < NCH; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_ch == CH_W'(i));

        // Slot i: hold the sample and its flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                samples[i*SW +: SW] <= '0;
                valid[i]            <= 1'b0;
            end else if (clear) begin
                valid[i] <= 1'b0;
            end else if (hit) begin
                samples[i*SW +: SW] <= wr_data;
                valid[i]            <= 1'b1;
            end
        end
    end

    // R7: a clear empties every flag by the next cycle.
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid == '0));

endmodule

// File: rtl/adc_scan_seq.sv
// Module: adc_scan_seq (top)
// Scan/direct-read controller for a serial 8-input converter whose reply lags
// the command by one frame. Holds cs_n low over all frames, appends a blank
// frame, drops the first reply and files each later reply under the channel
// commanded one frame earlier. Assumes the converter's reply bits [15:12] are 0.
module adc_scan_seq
    import adcseq_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int SW    = 12,
    parameter int DIV_W = 8,
    parameter int OVR_W = 8,
    parameter int CH_W  = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              scan_trig,
    input  logic [NCH-1:0]    chan_mask,
    input  logic              direct_req,
    input  logic [CH_W-1:0]   direct_chan,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              busy,
    output logic              scan_done,
    output logic [NCH*SW-1:0] samples,
    output logic [NCH-1:0]    sample_valid,
    output logic              direct_done,
    output logic [SW-1:0]     direct_data,
    output logic              direct_valid,
    output logic              direct_refused,
    output logic [OVR_W-1:0]  overrun_cnt
);
    localparam logic [OVR_W-1:0] OVR_MAX = '1;

    seq_state_t            state;
    logic [NCH-1:0]        rem_mask;
    logic [CH_W-1:0]       cur_ch;
    logic                  cur_dummy;
    logic [CH_W-1:0]       resp_ch;
    logic                  resp_live;
    logic                  is_direct;
    logic                  eng_start;
    logic [FRAME_BITS-1:0] tx_word;
    logic                  frame_done;
    logic [FRAME_BITS-1:0] rx_word;
    logic [NCH-1:0]        direct_oh;
    logic [NCH-1:0]        pick_src;
    logic                  pick_any;
    logic [CH_W-1:0]       pick_idx;
    logic                  accept_scan;
    logic                  accept_direct;
    logic                  bank_clear;
    logic                  bank_wr;

    assign busy          = (state != ST_IDLE);
    assign direct_oh     = NCH'(1) << direct_chan;
    assign accept_scan   = (state == ST_IDLE) && scan_trig;
    assign accept_direct = (state == ST_IDLE) && !scan_trig && direct_req;
    assign pick_src      = (state != ST_IDLE) ? rem_mask :
                           (scan_trig ? chan_mask : direct_oh);
    assign bank_clear    = accept_scan;
    assign bank_wr       = (state == ST_XFER) && frame_done && resp_live && !is_direct;

    adcseq_spi_engine #(.DIV_W(DIV_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (eng_start),
        .tx_word    (tx_word),
        .half_div   (clk_div),
        .miso       (miso),
        .sclk       (sclk),
        .mosi       (mosi),
        .frame_done (frame_done),
        .rx_word    (rx_word)
    );

    adcseq_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .mask (pick_src),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    adcseq_result_bank #(.NCH(NCH), .SW(SW), .CH_W(CH_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (bank_clear),
        .wr_en   (bank_wr),
        .wr_ch   (resp_ch),
        .wr_data (rx_word[SW-1:0]),
        .samples (samples),
        .valid   (sample_valid)
    );

    // Transfer sequencing: launch, per-frame reply filing, blank frame, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            rem_mask     <= '0;
            cur_ch       <= '0;
            cur_dummy    <= 1'b0;
            resp_ch      <= '0;
            resp_live    <= 1'b0;
            is_direct    <= 1'b0;
            eng_start    <= 1'b0;
            tx_word      <= '0;
            cs_n         <= 1'b1;
            scan_done    <= 1'b0;
            direct_done  <= 1'b0;
            direct_data  <= '0;
            direct_valid <= 1'b0;
        end else begin
            eng_start   <= 1'b0;
            scan_done   <= 1'b0;
            direct_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept_scan || accept_direct) begin
                        is_direct <= accept_direct;
                        if (accept_direct) direct_valid <= 1'b0;
                        if (!pick_any) begin
                            state <= ST_FIN;
                        end else begin
                            cs_n      <= 1'b0;
                            tx_word   <= mk_cmd(ADDR_W'(pick_idx));
                            eng_start <= 1'b1;
                            cur_ch    <= pick_idx;
                            cur_dummy <= 1'b0;
                            resp_live <= 1'b0;
                            rem_mask  <= pick_src & ~(NCH'(1) << pick_idx);
                            state     <= ST_XFER;
                        end
                    end
                end
                ST_XFER: begin
                    if (frame_done) begin
                        if (resp_live && is_direct) begin
                            direct_data  <= rx_word[SW-1:0];
                            direct_valid <= 1'b1;
                        end
                        resp_ch   <= cur_ch;
                        resp_live <= !cur_dummy;
                        if (cur_dummy) begin
                            cs_n  <= 1'b1;
                            state <= ST_FIN;
                        end else if (pick_any) begin
                            tx_word   <= mk_cmd(ADDR_W'(pick_idx));
                            eng_start <= 1'b1;
                            cur_ch    <= pick_idx;
                            rem_mask  <= rem_mask & ~(NCH'(1) << pick_idx);
                        end else begin
                            tx_word   <= '0;
                            eng_start <= 1'b1;
                            cur_dummy <= 1'b1;
                        end
                    end
                end
                ST_FIN: begin
                    scan_done   <= !is_direct;
                    direct_done <= is_direct;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Refusal pulse and overrun counting for requests that arrive while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            direct_refused <= 1'b0;
            overrun_cnt    <= '0;
        end else begin
            direct_refused <= direct_req && (busy || scan_trig);
            if (scan_trig && busy && overrun_cnt != OVR_MAX)
                overrun_cnt <= overrun_cnt + 1'b1;
        end
    end

    // R1: the serial clock idles high whenever chip select is released.
    a_r1_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R3: a reply that is kept carries zeros above the sample field.
    a_r3_reply_header_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && resp_live) |-> (rx_word[FRAME_BITS-1:SW] == '0));

    // R5: chip select stays low while frames are being exchanged.
    a_r5_cs_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |-> !cs_n);

    // R6: a completion pulse follows the chip select release by one cycle.
    a_r6_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> (scan_done || direct_done));

    // R9: a direct request during a transfer is refused.
    a_r9_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_req && busy) |=> direct_refused);

    // R10: a trigger during a transfer bumps the overrun count.
    a_r10_overrun_count: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_trig && busy && overrun_cnt != OVR_MAX) |=>
        (overrun_cnt == $past(overrun_cnt) + 1'b1));

    // R11: an empty mask completes without touching chip select.
    a_r11_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_trig && !busy && chan_mask == '0) |=> cs_n ##1 scan_done);

    // R13: simultaneous trigger and direct request while idle: the scan wins.
    a_r13_scan_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_trig && direct_req && !busy) |=> (direct_refused && busy && !is_direct));

endmodule

// File: tb/adc_scan_seq_tb.sv
// Directed bench with a behavioural one-frame-delay converter model.
module adc_scan_seq_tb;
    localparam int NCH = 8;
    localparam int SW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        clk_div = 8'd0;
    logic              scan_trig = 1'b0;
    logic [NCH-1:0]    chan_mask = '0;
    logic              direct_req = 1'b0;
    logic [2:0]        direct_chan = '0;
    logic              sclk, cs_n, mosi, busy, scan_done, direct_done;
    logic              direct_valid, direct_refused;
    logic              miso = 1'b0;
    logic [NCH*SW-1:0] samples;
    logic [NCH-1:0]    sample_valid;
    logic [SW-1:0]     direct_data;
    logic [7:0]        overrun_cnt;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    adc_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .scan_trig(scan_trig),
        .chan_mask(chan_mask), .direct_req(direct_req), .direct_chan(direct_chan),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy),
        .scan_done(scan_done), .samples(samples), .sample_valid(sample_valid),
        .direct_done(direct_done), .direct_data(direct_data),
        .direct_valid(direct_valid), .direct_refused(direct_refused),
        .overrun_cnt(overrun_cnt)
    );

    always #5 clk = ~clk;

    // Converter model: reply for frame N is the sample of the channel in frame N-1.
    logic [11:0] adc_val [NCH];
    logic [15:0] cmds [16];
    logic [15:0] out_sh = 16'hABCD;
    logic [15:0] in_sh = '0;
    int bitn = 0;
    int nframes = 0;
    int cs_falls = 0;
    int low_run = 0;
    int last_low = 0;
    int high_run = 0;
    int last_high = 0;

    always @(negedge cs_n) begin
        bitn = 0; nframes = 0; out_sh = 16'hABCD; cs_falls = cs_falls + 1;
    end
    always @(negedge sclk) begin
        if (cs_n === 1'b0) begin
            miso = out_sh[15];
            out_sh = {out_sh[14:0], 1'b0};
        end
    end
    always @(posedge sclk) begin
        if (cs_n === 1'b0) begin
            in_sh = {in_sh[14:0], mosi};
            bitn = bitn + 1;
            if (bitn == 16) begin
                if (nframes < 16) cmds[nframes] = in_sh;
                nframes = nframes + 1;
                bitn = 0;
                out_sh = {4'h0, adc_val[in_sh[13:11]]};
            end
        end
    end
    // Phase length monitor for the divider (R12).
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (sclk === 1'b0) low_run = low_run + 1;
        else if (low_run != 0) begin last_low = low_run; low_run = 0; end
        if (sclk === 1'b1 && cs_n === 1'b0 && bitn != 0) high_run = high_run + 1;
        else if (high_run != 0) begin last_high = high_run; high_run = 0; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_vals(input int seed);
        for (int i = 0; i < NCH; i++) adc_val[i] = 12'((seed * 37 + i * 291 + 5) & 12'hFFF);
    endtask

    // Waits for the selected done pulse; checks R6 chip select history on the way.
    task automatic wait_done(input bit direct, input bit used_cs);
        int n = 0;
        logic h1 = 1'b1, h2 = 1'b1;
        while (!(direct ? direct_done : scan_done) && n < 5000) begin
            h2 = h1; h1 = cs_n;
            @(negedge clk);
            n++;
        end
        chk(n < 5000, "R6 completion seen", n, 0);
        if (used_cs) chk(h1 == 1'b1 && h2 == 1'b0 && cs_n == 1'b1,
                         "R6 done one cycle after cs_n rise", {h2, h1}, 2'b01);
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1 idle lines", {cs_n, sclk}, 2'b11);
        chk(busy == 1'b0 && direct_valid == 1'b0, "R1 idle flags", {busy, direct_valid}, 0);
        chk(sample_valid == '0 && overrun_cnt == '0, "R1 cleared state",
            {sample_valid, overrun_cnt}, 0);
    endtask

    task automatic t_scan(input logic [7:0] m, input int div, input int seed);
        int falls0;
        int pc;
        int j;
        set_vals(seed);
        clk_div = 8'(div);
        falls0 = cs_falls;
        @(negedge clk); chan_mask = m; scan_trig = 1'b1;
        @(negedge clk); scan_trig = 1'b0;
        wait_done(1'b0, 1'b1);
        pc = $countones(m);
        chk(nframes == pc + 1, "R4 frame count", nframes, pc + 1);
        j = 0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (m[ch]) begin
                chk(cmds[j] == 16'(ch << 11), "R2 R4 command word", cmds[j], ch << 11);
                j++;
            end
        end
        chk(cmds[pc] == 16'h0, "R4 trailing blank frame", cmds[pc], 0);
        chk(sample_valid == m, "R7 valid flags", sample_valid, m);
        for (int ch = 0; ch < NCH; ch++)
            if (m[ch]) chk(samples[ch*SW +: SW] == adc_val[ch], "R3 sample filed",
                           samples[ch*SW +: SW], adc_val[ch]);
        chk(cs_falls - falls0 == 1, "R5 single chip select", cs_falls - falls0, 1);
        chk(last_low == div + 1, "R12 sclk low phase", last_low, div + 1);
        chk(last_high == div + 1, "R12 sclk high phase", last_high, div + 1);
    endtask

    task automatic t_zero_mask();
        int falls0 = cs_falls;
        @(negedge clk); chan_mask = '0; scan_trig = 1'b1;
        @(negedge clk); scan_trig = 1'b0;
        chk(busy == 1'b1 && cs_n == 1'b1, "R11 no chip select", cs_n, 1);
        @(negedge clk);
        chk(scan_done == 1'b1, "R11 done after two cycles", scan_done, 1);
        chk(sample_valid == '0, "R11 no valid flags", sample_valid, 0);
        chk(cs_falls == falls0 && sclk == 1'b1, "R11 no bus activity", cs_falls - falls0, 0);
    endtask

    task automatic t_direct(input logic [2:0] c, input int seed);
        logic [NCH*SW-1:0] s0 = samples;
        logic [NCH-1:0]    v0 = sample_valid;
        set_vals(seed);
        @(negedge clk); direct_chan = c; direct_req = 1'b1;
        @(negedge clk); direct_req = 1'b0;
        chk(direct_valid == 1'b0, "R8 valid dropped on accept", direct_valid, 0);
        wait_done(1'b1, 1'b1);
        chk(nframes == 2, "R8 two frames", nframes, 2);
        chk(cmds[0] == 16'({c, 11'd0}) && cmds[1] == 16'h0, "R8 command pair",
            cmds[0], {c, 11'd0});
        chk(direct_data == adc_val[c] && direct_valid, "R8 direct result",
            direct_data, adc_val[c]);
        chk(samples == s0 && sample_valid == v0, "R8 scan results untouched",
            sample_valid, v0);
    endtask

    task automatic t_busy_requests();
        logic [11:0] d0 = direct_data;
        logic [7:0]  o0 = overrun_cnt;
        set_vals(77);
        clk_div = 8'd1;
        @(negedge clk); chan_mask = 8'hFF; scan_trig = 1'b1;
        @(negedge clk); scan_trig = 1'b0;
        repeat (20) @(negedge clk);
        direct_chan = 3'd2; direct_req = 1'b1;
        @(negedge clk); direct_req = 1'b0;
        chk(direct_refused == 1'b1, "R9 refused pulse", direct_refused, 1);
        repeat (10) @(negedge clk);
        chan_mask = 8'h01; scan_trig = 1'b1;
        @(negedge clk); scan_trig = 1'b0;
        @(negedge clk); scan_trig = 1'b1;
        @(negedge clk); scan_trig = 1'b0;
        chk(overrun_cnt == o0 + 8'd2, "R10 overrun count", overrun_cnt, o0 + 2);
        wait_done(1'b0, 1'b1);
        chk(nframes == 9, "R10 scan undisturbed", nframes, 9);
        chk(sample_valid == 8'hFF, "R10 all flags", sample_valid, 8'hFF);
        chk(samples[7*SW +: SW] == adc_val[7], "R9 last channel sample",
            samples[7*SW +: SW], adc_val[7]);
        chk(direct_data == d0, "R9 direct data unchanged", direct_data, d0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && direct_done == 1'b0, "R9 no late direct read", busy, 0);
    endtask

    task automatic t_simultaneous();
        set_vals(5);
        clk_div = 8'd0;
        @(negedge clk); chan_mask = 8'h10; scan_trig = 1'b1;
        direct_chan = 3'd1; direct_req = 1'b1;
        @(negedge clk); scan_trig = 1'b0; direct_req = 1'b0;
        chk(direct_refused == 1'b1, "R13 direct refused", direct_refused, 1);
        wait_done(1'b0, 1'b1);
        chk(sample_valid == 8'h10 && samples[4*SW +: SW] == adc_val[4],
            "R13 scan executed", samples[4*SW +: SW], adc_val[4]);
    endtask

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        wait (cyc > 150000);
        vectors++; miscompares++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        set_vals(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scan(8'b1010_0101, 0, 1);
        t_scan(8'hFF, 3, 2);
        t_scan(8'h01, 0, 3);
        t_scan(8'h80, 2, 4);
        t_zero_mask();
        t_direct(3'd5, 9);
        t_direct(3'd0, 10);
        t_busy_requests();
        t_simultaneous();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule